// File: doc/BRIEF.md
# Synchronous Card Readout Sequencer

This block shifts stored bytes and protection flags out of a synchronous memory card, one bit per external card clock. It runs on the chip's system clock. It samples the card clock and card reset pins as already synchronized levels and finds their edges internally. Every change on the data line is made on a detected falling edge of the card clock. Bits leave least significant first. After the last bit, one extra card clock releases the line.

There are three readout cases:

- An answer-to-reset. It starts when the card reset pin falls after a card clock pulse was seen while reset was high. It streams the first four bytes.
- A main-memory read. It starts on a request pulse from the command logic and runs from a given address to the end of memory.
- A protection-flag read. It streams all 32 flag bits.

Raising the card reset pin while the card clock is low breaks any readout at once. The line is then released.

The data line is open drain and is modelled as a single level: 1 leaves the line released (high) and 0 pulls it low. The sequencer drives a byte address to the memory array and takes the addressed byte back in the same cycle. The protection flags arrive as a parallel vector. Command reception and programming are handled elsewhere.

Top module: `card_readout_seq`

## Requirements
- R1: After rst_ni is released, io_o is 1. Falling card clock edges while no readout is active leave it at 1.
- R2: The answer-to-reset starts on a falling edge of card_rst_i that follows at least one rising card_clk_i edge seen while card_rst_i was high. The first falling card clock edge after that puts bit 0 of byte 0 on io_o. A fall of card_rst_i with no such clock pulse starts nothing.
- R3: In the answer-to-reset, falling edge k (k = 1..32) drives bit (k-1) mod 8 of byte (k-1)/8, so bytes 0 to 3 are sent LSB first. Falling edge 33 sets io_o to 1.
- R4: A main-memory read from address N drives, on falling edge k, bit (k-1) mod 8 of byte N+(k-1)/8. It sends (256-N)*8 bits up to address 255, and the next falling edge sets io_o to 1 (total (256-N)*8+1 clocks).
- R5: A protection read (rd_prot_i = 1 with rd_req_i) drives prot_bits_i[k-1] on falling edge k for k = 1..32. Falling edge 33 sets io_o to 1.
- R6: A read request that arrives while a readout is active is ignored, and the running stream carries on unchanged.
- R7: A rising edge of card_rst_i while card_clk_i is 0 aborts any readout and sets io_o to 1 in the next system cycle. Later card clocks leave it high, and a new read request afterwards runs normally.
- R8: io_o changes only on a falling card clock edge, except when a break or an answer-to-reset start forces it high. A read request alone leaves io_o unchanged.
- R9: After a readout has released the line, further card clocks keep io_o at 1.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| card_clk_i | input | 1 | Synchronized card clock level |
| card_rst_i | input | 1 | Synchronized card reset level |
| rd_req_i | input | 1 | One-cycle read request from command logic |
| rd_prot_i | input | 1 | 1 selects a protection read, 0 a main-memory read |
| rd_addr_i | input | ADDR_W | Start byte address of a main-memory read |
| mem_addr_o | output | ADDR_W | Byte address to the memory array |
| mem_data_i | input | 8 | Byte returned for mem_addr_o in the same cycle |
| prot_bits_i | input | PROT_BITS | Protection flags, bit i for byte i |
| io_o | output | 1 | Data line level: 1 released, 0 pulled low |

## Verification
The hardest case to reach is a break that lands in the middle of a main-memory read while the line is being pulled low. A release to 1 can only be seen if the line was low just before it. The stimulus therefore clears the byte at the read's start address, clocks out three zero bits, and raises card reset during the low clock phase. It then lowers reset with no clock pulse in between, which must not start an answer-to-reset. It also checks that a fresh read still runs after the break. A second hard case is a request that overlaps a stream: a protection read is asked for in the middle of a main-memory read, and the scoreboard keeps expecting main-memory bits.

// File: rtl/card_readout_pkg.sv
package card_readout_pkg;
  typedef enum logic [1:0] {
    MD_IDLE = 2'd0,
    MD_ATR  = 2'd1,
    MD_MAIN = 2'd2,
    MD_PROT = 2'd3
  } rd_mode_e;
endpackage

// File: rtl/card_edge_det.sv
module card_edge_det #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= '0;
    else         sig_q <= sig_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign rise_o[i] = sig_i[i] & ~sig_q[i];
    assign fall_o[i] = ~sig_i[i] & sig_q[i];
  end
endmodule

// File: rtl/card_bit_sel.sv
module card_bit_sel #(
  parameter int ADDR_W    = 8,
  parameter int PROT_BITS = 32
) (
  input  logic [ADDR_W+2:0]    ptr_i,
  input  logic                 sel_prot_i,
  input  logic [7:0]           mem_data_i,
  input  logic [PROT_BITS-1:0] prot_bits_i,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic                 bit_o
);
  localparam int PIDX_W = $clog2(PROT_BITS);

  logic [PIDX_W-1:0] pidx;

  assign pidx       = ptr_i[PIDX_W-1:0];
  assign mem_addr_o = ptr_i[ADDR_W+2:3];
  assign bit_o      = sel_prot_i ? prot_bits_i[pidx] : mem_data_i[ptr_i[2:0]];
endmodule

// File: rtl/card_readout_seq.sv
module card_readout_seq
  import card_readout_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PROT_BITS = 32,
  parameter int ATR_BYTES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 card_clk_i,
  input  logic                 card_rst_i,
  input  logic                 rd_req_i,
  input  logic                 rd_prot_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [ADDR_W-1:0]    mem_addr_o,
  input  logic [7:0]           mem_data_i,
  input  logic [PROT_BITS-1:0] prot_bits_i,
  output logic                 io_o
);
  localparam int MEM_BYTES = 1 << ADDR_W;
  localparam int PTR_W     = ADDR_W + 4;
  localparam logic [PTR_W-1:0] MAIN_END = PTR_W'(MEM_BYTES * 8);
  localparam logic [PTR_W-1:0] ATR_END  = PTR_W'(ATR_BYTES * 8);
  localparam logic [PTR_W-1:0] PROT_END = PTR_W'(PROT_BITS);

  rd_mode_e         mode_q;
  logic [PTR_W-1:0] ptr_q, end_q;   // ptr: {byte address, bit index}
  logic             io_q, arm_q;
  logic [1:0]       rise, fall;
  logic             clk_rise, clk_fall, rst_rise, rst_fall;
  logic             brk, atr_go, cur_bit;

  card_edge_det #(.W(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({card_rst_i, card_clk_i}),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign clk_rise = rise[0];
  assign clk_fall = fall[0];
  assign rst_rise = rise[1];
  assign rst_fall = fall[1];
  assign brk      = rst_rise & ~card_clk_i;
  assign atr_go   = rst_fall & arm_q;

  card_bit_sel #(.ADDR_W(ADDR_W), .PROT_BITS(PROT_BITS)) u_sel (
    .ptr_i       (ptr_q[PTR_W-2:0]),
    .sel_prot_i  (mode_q == MD_PROT),
    .mem_data_i  (mem_data_i),
    .prot_bits_i (prot_bits_i),
    .mem_addr_o  (mem_addr_o),
    .bit_o       (cur_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MD_IDLE;
      ptr_q  <= '0;
      end_q  <= '0;
      io_q   <= 1'b1;
      arm_q  <= 1'b0;
    end else if (brk) begin
      mode_q <= MD_IDLE;
      io_q   <= 1'b1;
      arm_q  <= 1'b0;
    end else if (atr_go) begin
      mode_q <= MD_ATR;
      ptr_q  <= '0;
      end_q  <= ATR_END;
      io_q   <= 1'b1;
      arm_q  <= 1'b0;
    end else begin
      // clock pulse during reset arms the answer-to-reset
      if (clk_rise && card_rst_i) arm_q <= 1'b1;
      if (mode_q != MD_IDLE && clk_fall) begin
        if (ptr_q == end_q) begin
          io_q   <= 1'b1;
          mode_q <= MD_IDLE;
        end else begin
          io_q  <= cur_bit;
          ptr_q <= ptr_q + 1'b1;
        end
      end else if (mode_q == MD_IDLE && rd_req_i) begin
        mode_q <= rd_prot_i ? MD_PROT : MD_MAIN;
        ptr_q  <= rd_prot_i ? '0 : {1'b0, rd_addr_i, 3'b000};
        end_q  <= rd_prot_i ? PROT_END : MAIN_END;
      end
    end
  end

  assign io_o = io_q;

  // R1
  idle_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MD_IDLE) |-> io_q);

  // R4
  ptr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MD_IDLE) |-> (ptr_q <= end_q));

  // R6
  busy_req_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && mode_q != MD_IDLE && !clk_fall && !brk && !atr_go)
      |=> ($stable(mode_q) && $stable(ptr_q) && $stable(end_q)));

  // R7
  break_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_rise && !card_clk_i) |=> (io_q && mode_q == MD_IDLE));

  // R8
  low_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(io_q) |-> $past(clk_fall));

  // R8
  high_on_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(io_q) |-> ($past(clk_fall) || $past(rst_rise) || $past(rst_fall)));
endmodule

// File: tb/card_readout_seq_test.sv
`timescale 1ns/1ps
module card_readout_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        card_clk = 1'b0;
  logic        card_rst = 1'b0;
  logic        rd_req = 1'b0;
  logic        rd_prot = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  mem_addr;
  logic [7:0]  mem_data;
  logic [31:0] prot_bits = 32'hA5C3_1E69;
  logic        io;

  logic [7:0]  mem [256];
  bit          exp_q[$];
  string       tag_q[$];
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  assign mem_data = mem[mem_addr];

  card_readout_seq uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .card_clk_i  (card_clk),
    .card_rst_i  (card_rst),
    .rd_req_i    (rd_req),
    .rd_prot_i   (rd_prot),
    .rd_addr_i   (rd_addr),
    .mem_addr_o  (mem_addr),
    .mem_data_i  (mem_data),
    .prot_bits_i (prot_bits),
    .io_o        (io)
  );

  task automatic chk(input bit act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: io=%0b expected %0b", tag, act, exp);
    end
  endtask

  // driver: push expectation, then one card clock pulse
  task automatic pulse(input bit e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    card_clk = 1'b1;
    repeat (4) @(negedge clk);
    card_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic request(input bit prot, input logic [7:0] addr);
    rd_req  = 1'b1;
    rd_prot = prot;
    rd_addr = addr;
    @(negedge clk);
    rd_req  = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic main_stream(input int n, input int skip, input string tag);
    for (int k = skip; k < (256 - n) * 8; k++)
      pulse(mem[n + k / 8][k % 8], tag);
    pulse(1'b1, tag);
  endtask

  // monitor: compare io after each falling card clock edge
  initial begin
    forever begin
      @(negedge card_clk);
      repeat (3) @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(io, e, t);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: expired expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 29) ^ 8'h5A;
    mem[200] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(io, 1'b1, "R1 reset");
    for (int i = 0; i < 3; i++) pulse(1'b1, "R1 idle clock");

    // answer-to-reset
    card_rst = 1'b1;
    repeat (4) @(negedge clk);
    pulse(1'b1, "R2 clock under reset");
    card_rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(io, 1'b1, "R2 before first edge");
    pulse(mem[0][0], "R2 first bit");
    for (int k = 1; k < 32; k++) pulse(mem[k / 8][k % 8], "R3 atr bit");
    pulse(1'b1, "R3 release");
    pulse(1'b1, "R9 extra clock");
    pulse(1'b1, "R9 extra clock");

    // reset fall without clock pulse
    card_rst = 1'b1;
    repeat (4) @(negedge clk);
    card_rst = 1'b0;
    repeat (4) @(negedge clk);
    pulse(1'b1, "R2 no pulse no atr");
    pulse(1'b1, "R2 no pulse no atr");

    // main reads
    request(1'b0, 8'd250);
    chk(io, 1'b1, "R8 request only");
    main_stream(250, 0, "R4 n=250");
    request(1'b0, 8'd255);
    main_stream(255, 0, "R4 n=255");
    pulse(1'b1, "R9 after read");
    request(1'b0, 8'd0);
    main_stream(0, 0, "R4 n=0");

    // protection read
    request(1'b1, 8'd77);
    for (int k = 0; k < 32; k++) pulse(prot_bits[k], "R5 prot bit");
    pulse(1'b1, "R5 release");

    // request during a running stream
    request(1'b0, 8'd252);
    for (int k = 0; k < 5; k++) pulse(mem[252 + k / 8][k % 8], "R6 before");
    request(1'b1, 8'd0);
    main_stream(252, 5, "R6 continues");

    // break mid-read while line is low
    request(1'b0, 8'd200);
    for (int k = 0; k < 3; k++) pulse(1'b0, "R7 zero bits");
    chk(io, 1'b0, "R7 line low");
    card_rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(io, 1'b1, "R7 break release");
    card_rst = 1'b0;
    repeat (4) @(negedge clk);
    pulse(1'b1, "R7 after break");
    pulse(1'b1, "R7 after break");
    request(1'b0, 8'd254);
    main_stream(254, 0, "R7 read after break");

    repeat (8) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule